// File: doc/BRIEF.md
# Debug Single-Step Trace Sequencer

This block runs the single-step command of an on-chip debug unit for a small processor core that is parked in debug mode. When the host strobes a trace command, the sequencer takes the saved return address off the hardware stack. It may reinstate the global interrupt enable. It then opens a window in which the core fetches and runs exactly one instruction from that address.

Once the core reports that the instruction has finished, the sequencer freezes the core and keeps any further fetch away from program memory. It pushes the advanced instruction pointer back onto the stack and forces the instruction pointer to the fixed debug vector 16'h8010. It then masks interrupts and parks the core again.

A two-bit status tells the host whether the core is outside debug mode, waiting in debug mode, or busy with a step. The stack is reached through pop and push request/acknowledge handshakes. The host serial link and the core datapath sit outside this block.

Top module: `trace_step_ctrl`

## Requirements
- R1: A synchronous active-high reset gives status 2'b00 and drives every control output and data output to zero.
- R2: Status encodes 2'b00 outside debug, 2'b01 debug-idle and 2'b10 debug-busy. A debug-entry pulse outside debug gives status 2'b01 with halt high one cycle later, and it records the interrupt-enable input of that cycle. A debug-exit pulse in debug-idle returns the status to 2'b00.
- R3: A trace strobe sampled in debug-idle gives status 2'b10 and pop_req high one cycle later. pop_req stays high until pop_ack is sampled.
- R4: In the cycle after pop_ack, the interrupt-enable write strobe is high with value 1 only if the recorded enable was 1. Otherwise the strobe stays low.
- R5: In the next cycle, run_en and fetch_en are high for exactly one cycle, and fetch_addr equals the popped address.
- R6: From the cycle after the run window until the instruction-pointer load, fetch_block is high and fetch_en stays low, whatever the latency of instr_done.
- R7: One cycle after instr_done is sampled, stall and push_req go high and push_data holds the ip_next value sampled with instr_done. push_req holds until push_ack is sampled.
- R8: In the cycle after push_ack, ip_load is high for one cycle with ip_load_val = 16'h8010. In the same cycle the interrupt-enable write strobe is high with value 0.
- R9: The next cycle shows halt high with status still 2'b10. The cycle after that shows status 2'b01 with halt high.
- R10: A trace strobe has no effect while the status is 2'b00 or 2'b10. The status and all controls follow only the sequence already in progress, or stay put.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_enter | input | 1 | Pulse: core has entered debug mode |
| dbg_exit | input | 1 | Pulse: host leaves debug mode |
| ie_in | input | 1 | Core's global interrupt-enable flag |
| trace_cmd | input | 1 | Host single-step strobe |
| dbg_status | output | 2 | 00 off, 01 debug-idle, 10 debug-busy |
| halt | output | 1 | Core held halted |
| pop_req | output | 1 | Stack pop request |
| pop_ack | input | 1 | Stack pop acknowledge |
| pop_data | input | AW | Address returned by the pop |
| fetch_addr | output | AW | Address for the single fetch |
| fetch_en | output | 1 | Permit one program fetch |
| run_en | output | 1 | One-cycle normal-execution window |
| fetch_block | output | 1 | Suppress program memory fetches |
| instr_done | input | 1 | Core finished the stepped instruction |
| ip_next | input | AW | Core's incremented instruction pointer |
| stall | output | 1 | Stall the core pipeline |
| push_req | output | 1 | Stack push request |
| push_ack | input | 1 | Stack push acknowledge |
| push_data | output | AW | Return address to push |
| ip_load | output | 1 | Load the instruction pointer |
| ip_load_val | output | AW | Value for the instruction-pointer load |
| ie_we | output | 1 | Write strobe for the interrupt-enable flag |
| ie_wval | output | 1 | Value written to the interrupt-enable flag |

## Verification
Every output is a flop, so each result appears at the first clock edge after the input that causes it. Status and pop_req follow a trace strobe by one cycle. The enable write and the run window come one and two cycles after pop_ack. Stall and push follow instr_done by one cycle, and the vector load and the return to idle come one and three cycles after push_ack. The bench's reference model moves on the same edge as the design and compares every output half a cycle later. The acknowledge and completion latencies are varied from zero to several cycles, so no check depends on a fixed distance from the trace strobe.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [3:0] {
    ST_OFF, ST_IDLE, ST_POP, ST_IE, ST_RUN, ST_WAIT, ST_PUSH, ST_VEC, ST_HALT
  } trc_state_e;

  localparam logic [1:0] STAT_OFF  = 2'b00;
  localparam logic [1:0] STAT_IDLE = 2'b01;
  localparam logic [1:0] STAT_BUSY = 2'b10;

  typedef struct packed {
    logic [1:0] status;
    logic       halt;
    logic       pop_req;
    logic       run_en;
    logic       fetch_en;
    logic       fetch_block;
    logic       stall;
    logic       push_req;
    logic       ip_load;
    logic       ie_we;
    logic       ie_wval;
  } trc_ctl_t;

  // Control word shown while the sequencer sits in a given state.
  function automatic trc_ctl_t ctl_decode(trc_state_e s, logic saved_ie);
    trc_ctl_t c;
    c = '0;
    case (s)
      ST_IDLE: begin c.status = STAT_IDLE; c.halt = 1'b1; end
      ST_POP:  begin c.status = STAT_BUSY; c.halt = 1'b1; c.pop_req = 1'b1; end
      ST_IE:   begin
        c.status = STAT_BUSY; c.halt = 1'b1;
        c.ie_we = saved_ie; c.ie_wval = saved_ie;
      end
      ST_RUN:  begin c.status = STAT_BUSY; c.run_en = 1'b1; c.fetch_en = 1'b1; end
      ST_WAIT: begin c.status = STAT_BUSY; c.fetch_block = 1'b1; end
      ST_PUSH: begin
        c.status = STAT_BUSY; c.fetch_block = 1'b1; c.stall = 1'b1; c.push_req = 1'b1;
      end
      ST_VEC:  begin
        c.status = STAT_BUSY; c.fetch_block = 1'b1; c.stall = 1'b1;
        c.ip_load = 1'b1; c.ie_we = 1'b1; c.ie_wval = 1'b0;
      end
      ST_HALT: begin c.status = STAT_BUSY; c.halt = 1'b1; end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/trace_fsm.sv
module trace_fsm
  import trace_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dbg_enter,
  input  logic       dbg_exit,
  input  logic       trace_cmd,
  input  logic       pop_ack,
  input  logic       instr_done,
  input  logic       push_ack,
  output trc_state_e state_q,
  output trc_state_e state_d
);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:  if (dbg_enter) state_d = ST_IDLE;
      ST_IDLE: begin
        if (dbg_exit)       state_d = ST_OFF;
        else if (trace_cmd) state_d = ST_POP;
      end
      ST_POP:  if (pop_ack)    state_d = ST_IE;
      ST_IE:   state_d = ST_RUN;
      ST_RUN:  state_d = ST_WAIT;
      ST_WAIT: if (instr_done) state_d = ST_PUSH;
      ST_PUSH: if (push_ack)   state_d = ST_VEC;
      ST_VEC:  state_d = ST_HALT;
      ST_HALT: state_d = ST_IDLE;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OFF;
    else     state_q <= state_d;
  end

  // R3: the pop state is left only on an acknowledge
  a_r3_pop_wait: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_POP && !pop_ack) |=> state_q == ST_POP);

  // R7: the push state is left only on an acknowledge
  a_r7_push_wait: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PUSH && !push_ack) |=> state_q == ST_PUSH);

endmodule

// File: rtl/trace_ctx_regs.sv
module trace_ctx_regs
  import trace_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  trc_state_e    state_q,
  input  logic          dbg_enter,
  input  logic          ie_in,
  input  logic          pop_ack,
  input  logic [AW-1:0] pop_data,
  input  logic          instr_done,
  input  logic [AW-1:0] ip_next,
  output logic [AW-1:0] ret_addr,
  output logic [AW-1:0] resume_ip,
  output logic          saved_ie
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_addr  <= '0;
      resume_ip <= '0;
      saved_ie  <= 1'b0;
    end else begin
      if (state_q == ST_OFF && dbg_enter)   saved_ie  <= ie_in;
      if (state_q == ST_POP && pop_ack)     ret_addr  <= pop_data;
      if (state_q == ST_WAIT && instr_done) resume_ip <= ip_next;
    end
  end

  // R5: the fetch address does not move while the step is running
  a_r5_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN || state_q == ST_WAIT) |=> $stable(ret_addr));

endmodule

// File: rtl/trace_ctl_regs.sv
module trace_ctl_regs
  import trace_pkg::*;
#(
  parameter int              AW      = 16,
  parameter logic [AW-1:0]   DBG_VEC = 16'h8010
) (
  input  logic          clk,
  input  logic          rst,
  input  trc_state_e    state_d,
  input  logic          saved_ie,
  output trc_ctl_t      ctl_q,
  output logic [AW-1:0] vec_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      vec_q <= '0;
    end else begin
      ctl_q <= ctl_decode(state_d, saved_ie);
      vec_q <= (state_d == ST_VEC) ? DBG_VEC : '0;
    end
  end

  // R6: a blocked fetch and a permitted fetch never coincide
  a_r6_no_fetch_when_blocked: assert property (@(posedge clk) disable iff (rst)
    ctl_q.fetch_block |-> !ctl_q.fetch_en);

  // R1/R2: the reserved status code never appears
  a_r2_status_legal: assert property (@(posedge clk) disable iff (rst)
    ctl_q.status != 2'b11);

endmodule

// File: rtl/trace_step_ctrl.sv
module trace_step_ctrl
  import trace_pkg::*;
#(
  parameter int            AW      = 16,
  parameter logic [AW-1:0] DBG_VEC = 16'h8010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbg_enter,
  input  logic          dbg_exit,
  input  logic          ie_in,
  input  logic          trace_cmd,
  output logic [1:0]    dbg_status,
  output logic          halt,
  output logic          pop_req,
  input  logic          pop_ack,
  input  logic [AW-1:0] pop_data,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_en,
  output logic          run_en,
  output logic          fetch_block,
  input  logic          instr_done,
  input  logic [AW-1:0] ip_next,
  output logic          stall,
  output logic          push_req,
  input  logic          push_ack,
  output logic [AW-1:0] push_data,
  output logic          ip_load,
  output logic [AW-1:0] ip_load_val,
  output logic          ie_we,
  output logic          ie_wval
);

  trc_state_e state_q, state_d;
  trc_ctl_t   ctl_q;
  logic       saved_ie;

  trace_fsm u_fsm (
    .clk, .rst, .dbg_enter, .dbg_exit, .trace_cmd,
    .pop_ack, .instr_done, .push_ack,
    .state_q, .state_d
  );

  trace_ctx_regs #(.AW(AW)) u_ctx (
    .clk, .rst, .state_q, .dbg_enter, .ie_in,
    .pop_ack, .pop_data, .instr_done, .ip_next,
    .ret_addr(fetch_addr), .resume_ip(push_data), .saved_ie
  );

  trace_ctl_regs #(.AW(AW), .DBG_VEC(DBG_VEC)) u_ctl (
    .clk, .rst, .state_d, .saved_ie,
    .ctl_q, .vec_q(ip_load_val)
  );

  assign dbg_status  = ctl_q.status;
  assign halt        = ctl_q.halt;
  assign pop_req     = ctl_q.pop_req;
  assign run_en      = ctl_q.run_en;
  assign fetch_en    = ctl_q.fetch_en;
  assign fetch_block = ctl_q.fetch_block;
  assign stall       = ctl_q.stall;
  assign push_req    = ctl_q.push_req;
  assign ip_load     = ctl_q.ip_load;
  assign ie_we       = ctl_q.ie_we;
  assign ie_wval     = ctl_q.ie_wval;

  // R3: a trace strobe while idle starts the pop one cycle later
  a_r3_cmd_starts_pop: assert property (@(posedge clk) disable iff (rst)
    (dbg_status == STAT_IDLE && trace_cmd && !dbg_exit) |=>
      (dbg_status == STAT_BUSY && pop_req));

  // R5: the execution window lasts one cycle
  a_r5_single_run: assert property (@(posedge clk) disable iff (rst)
    run_en |=> !run_en);

  // R7: a pending push keeps its request and data
  a_r7_push_hold: assert property (@(posedge clk) disable iff (rst)
    (push_req && !push_ack) |=> (push_req && $stable(push_data)));

  // R8: the pointer load carries the debug vector and masks interrupts
  a_r8_vector_load: assert property (@(posedge clk) disable iff (rst)
    ip_load |-> (ip_load_val == DBG_VEC && ie_we && !ie_wval));

  // R10: a strobe while busy does not restart the pop
  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (dbg_status == STAT_BUSY && !pop_req && trace_cmd) |=> !pop_req);

endmodule

// File: tb/sim_trace_step_ctrl.sv
`timescale 1ns/1ps
module sim_trace_step_ctrl;

  localparam int AW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          dbg_enter = 0, dbg_exit = 0, ie_in = 0, trace_cmd = 0;
  logic          pop_ack = 0, push_ack = 0, instr_done = 0;
  logic [AW-1:0] pop_data = '0, ip_next = '0;
  logic [1:0]    dbg_status;
  logic          halt, pop_req, fetch_en, run_en, fetch_block, stall, push_req;
  logic          ip_load, ie_we, ie_wval;
  logic [AW-1:0] fetch_addr, push_data, ip_load_val;

  trace_step_ctrl #(.AW(AW), .DBG_VEC(16'h8010)) u0 (
    .clk, .rst, .dbg_enter, .dbg_exit, .ie_in, .trace_cmd,
    .dbg_status, .halt, .pop_req, .pop_ack, .pop_data,
    .fetch_addr, .fetch_en, .run_en, .fetch_block,
    .instr_done, .ip_next, .stall, .push_req, .push_ack, .push_data,
    .ip_load, .ip_load_val, .ie_we, .ie_wval
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // Reference model: phase names follow the requirement steps
  // 0 off, 1 idle, 2 popping, 3 enable restore, 4 run, 5 waiting,
  // 6 pushing, 7 vector load, 8 halt
  int            ph = 0;
  bit            m_ie = 0;
  logic [AW-1:0] m_ret = '0, m_ip = '0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin ph = 0; m_ie = 0; m_ret = '0; m_ip = '0; end
    else begin
      if (ph == 0) begin
        if (dbg_enter) begin ph = 1; m_ie = ie_in; end
      end else if (ph == 1) begin
        if (dbg_exit) ph = 0; else if (trace_cmd) ph = 2;
      end else if (ph == 2) begin
        if (pop_ack) begin m_ret = pop_data; ph = 3; end
      end else if (ph == 5) begin
        if (instr_done) begin m_ip = ip_next; ph = 6; end
      end else if (ph == 6) begin
        if (push_ack) ph = 7;
      end else if (ph == 8) ph = 1;
      else ph = ph + 1;
    end
  end

  // Compare every output half a cycle after each edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 R3 R9 status", {30'd0, dbg_status},
          {30'd0, (ph == 0) ? 2'b00 : (ph == 1) ? 2'b01 : 2'b10});
      chk("R2 R9 halt", {31'd0, halt}, {31'd0, (ph == 1 || ph == 2 || ph == 3 || ph == 8)});
      chk("R3 pop_req", {31'd0, pop_req}, {31'd0, ph == 2});
      chk("R4 R8 ie_we", {31'd0, ie_we}, {31'd0, (ph == 3 && m_ie) || ph == 7});
      if (ie_we) chk("R4 R8 ie_wval", {31'd0, ie_wval}, {31'd0, ph == 3});
      chk("R5 run_en", {31'd0, run_en}, {31'd0, ph == 4});
      chk("R5 fetch_en", {31'd0, fetch_en}, {31'd0, ph == 4});
      if (ph == 4) chk("R5 fetch_addr", {16'd0, fetch_addr}, {16'd0, m_ret});
      chk("R6 fetch_block", {31'd0, fetch_block}, {31'd0, ph >= 5 && ph <= 7});
      chk("R7 stall", {31'd0, stall}, {31'd0, ph == 6 || ph == 7});
      chk("R7 push_req", {31'd0, push_req}, {31'd0, ph == 6});
      if (ph == 6) chk("R7 push_data", {16'd0, push_data}, {16'd0, m_ip});
      chk("R8 ip_load", {31'd0, ip_load}, {31'd0, ph == 7});
      if (ph == 7) chk("R8 ip_load_val", {16'd0, ip_load_val}, 32'h8010);
    end
  end

  // Stack and core responders with programmable latency
  int pop_dly = 0, push_dly = 0, done_dly = 0;
  int pc = 0, qc = 0, dc = 0;
  bit armed = 0;
  always @(negedge clk) begin
    if (pop_ack) begin pop_ack <= 0; pc <= 0; end
    else if (pop_req) begin if (pc >= pop_dly) pop_ack <= 1; else pc <= pc + 1; end
    if (push_ack) begin push_ack <= 0; qc <= 0; end
    else if (push_req) begin if (qc >= push_dly) push_ack <= 1; else qc <= qc + 1; end
    if (instr_done) instr_done <= 0;
    else if (run_en) begin armed <= 1; dc <= 0; end
    else if (armed) begin
      if (dc >= done_dly) begin instr_done <= 1; armed <= 0; end
      else dc <= dc + 1;
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic run_step(input logic [AW-1:0] ra, input logic [AW-1:0] nx,
                          input int pd, input int dd, input int qd);
    pop_data = ra; ip_next = nx; pop_dly = pd; done_dly = dd; push_dly = qd;
    pulse(trace_cmd);
    repeat (2) @(negedge clk);
    trace_cmd = 1;               // R10: strobe while busy
    @(negedge clk); trace_cmd = 0;
    for (int i = 0; i < 60 && dbg_status != 2'b01; i++) @(negedge clk);
    chk("R9 back to idle", {30'd0, dbg_status}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status after reset", {30'd0, dbg_status}, 32'd0);
    chk("R1 controls after reset",
        {20'd0, halt, pop_req, run_en, fetch_en, fetch_block, stall,
         push_req, ip_load, ie_we, ie_wval, 2'b00}, 32'd0);
    chk("R1 data after reset", {fetch_addr, push_data | ip_load_val}, 32'd0);
    rst = 0;
    @(negedge clk);
    pulse(trace_cmd);            // R10: ignored while off
    @(negedge clk);
    chk("R10 off ignores trace", {30'd0, dbg_status}, 32'd0);

    ie_in = 1; pulse(dbg_enter); ie_in = 0;
    run_step(16'h1234, 16'h1235, 2, 1, 0);
    run_step(16'hFFFF, 16'h0000, 0, 3, 2);
    repeat (4) @(negedge clk);
    chk("R10 idle stays idle", {30'd0, dbg_status}, 32'd1);

    pulse(dbg_exit);
    @(negedge clk);
    chk("R2 exit to off", {30'd0, dbg_status}, 32'd0);
    ie_in = 0; pulse(dbg_enter); ie_in = 1;
    run_step(16'h0400, 16'h0402, 1, 0, 4);
    run_step(16'h8010, 16'h8011, 0, 0, 0);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (!finished && cyc > 20000) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule